// File: doc/BRIEF.md
# Periodic Interrupt and Event Flag Unit

This unit sits beside a real-time clock core. It divides a 32.768 kHz time base, delivered as a one-cycle enable pulse on `tick`, into a periodic event whose period a 4-bit rate code selects. It collects that event with the alarm and update-ended pulses from the clock core into a read-only flag byte. A summary bit in that byte drives the interrupt line.

Each source has its own enable bit in the control input. Disabled sources still raise their flag, but they do not assert the interrupt. A read strobe clears the flags. The same divider also produces a square wave at the periodic rate when the square-wave enable is set.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After reset, `flags` is 00h, and `irq` and `sqw` are low.
- R2: Rate code 0000b produces no periodic event, so flag bit 6 stays clear, and it holds `sqw` low.
- R3: For rate codes 3 to 15, with P = 2^(code-1), a periodic event occurs on each `tick` that makes the count of ticks since reset a multiple of P. It sets flag bit 6 after that clock edge. Code 3 gives 4 ticks (about 122 us), code 6 gives 32 ticks (976.562 us) and code 15 gives 16384 ticks (500 ms).
- R4: Rate codes 0001b and 0010b give the same periods as codes 1000b and 1001b.
- R5: An `alarm_evt` pulse sets flag bit 5 and an `upd_evt` pulse sets flag bit 4 at that clock edge, whatever the enables are.
- R6: Flag bit 7 is high exactly when some flag is set together with its enable: bit 6 with `ctrl_en[6]`, bit 5 with `ctrl_en[5]`, bit 4 with `ctrl_en[4]`. `irq` equals flag bit 7.
- R7: A cycle with `flag_rd` high clears flag bits 7..4 at its clock edge. An event arriving in that same cycle is kept set.
- R8: Flag bits 3..0 always read as zero.
- R9: With `ctrl_en[3]` high and a nonzero rate code, `sqw` is high while (ticks since reset mod P) is at least P/2 and low otherwise. With `ctrl_en[3]` low, `sqw` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 32.768 kHz time-base enable |
| rate_sel | input | 4 | Periodic rate code |
| ctrl_en | input | 4 (bits 6:3) | Enables: 6 periodic, 5 alarm, 4 update-ended, 3 square wave |
| alarm_evt | input | 1 | Alarm match pulse from the clock core |
| upd_evt | input | 1 | Update-ended pulse from the clock core |
| flag_rd | input | 1 | Flag-register read strobe |
| flags | output | 8 | Flag byte: 7 summary, 6 periodic, 5 alarm, 4 update-ended |
| irq | output | 1 | Interrupt request |
| sqw | output | 1 | Square-wave output |

## Verification
Every result is due one edge after its cause. An event or read strobe at a rising edge shows up in `flags` and `irq` right after that edge. A `tick` moves the divider at that edge, so `sqw` follows it at once. The bench changes its inputs 1 ns after a rising edge, so each edge sees one settled set of inputs. It then compares every output 1 ns after the next edge against a model of ticks since reset and the three flags. The summary bit is compared against the current enables, since it is not registered.

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq #(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [6:3]        ctrl_en,
  input  logic              alarm_evt,
  input  logic              upd_evt,
  input  logic              flag_rd,
  output logic [7:0]        flags,
  output logic              irq,
  output logic              sqw
);
  localparam int DIV_W = (1 << RATE_W) - 2;

  logic [DIV_W-1:0]  div_q;
  logic [RATE_W-1:0] eff_code;
  logic [RATE_W-1:0] shift_amt;
  logic [DIV_W:0]    span;
  logic [DIV_W-1:0]  mask;
  logic [DIV_W-1:0]  half;
  logic              rate_on;
  logic              per_evt;
  logic              pf_q, af_q, uf_q;
  logic              summary;

  always_comb begin
    case (rate_sel)
      RATE_W'(1): eff_code = RATE_W'(8);
      RATE_W'(2): eff_code = RATE_W'(9);
      default:    eff_code = rate_sel;
    endcase
  end

  assign rate_on   = (rate_sel != '0);
  assign shift_amt = eff_code - RATE_W'(1);
  assign span      = (DIV_W+1)'(1) << shift_amt;
  assign mask      = DIV_W'(span - (DIV_W+1)'(1));
  assign half      = DIV_W'(span >> 1);
  assign per_evt   = tick && rate_on && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)    div_q <= '0;
    else if (tick) div_q <= div_q + DIV_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_q <= 1'b0;
      af_q <= 1'b0;
      uf_q <= 1'b0;
    end else begin
      pf_q <= per_evt   | (pf_q & ~flag_rd);
      af_q <= alarm_evt | (af_q & ~flag_rd);
      uf_q <= upd_evt   | (uf_q & ~flag_rd);
    end
  end

  assign summary = |({pf_q, af_q, uf_q} & ctrl_en[6:4]);
  assign flags   = {summary, pf_q, af_q, uf_q, 4'b0000};
  assign irq     = summary;
  assign sqw     = ctrl_en[3] && rate_on && |(div_q & half);

  AST_PER_SETS:   assert property (@(posedge clk) disable iff (!rst_n) per_evt |=> flags[6]); // R3
  AST_ZERO_RATE:  assert property (@(posedge clk) disable iff (!rst_n) (rate_sel == '0 && !flags[6]) |=> !flags[6]); // R2
  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n) alarm_evt |=> flags[5]); // R5
  AST_UPD_SETS:   assert property (@(posedge clk) disable iff (!rst_n) upd_evt |=> flags[4]); // R5
  AST_RD_CLEARS:  assert property (@(posedge clk) disable iff (!rst_n) (flag_rd && !alarm_evt) |=> !flags[5]); // R7
  AST_IRQ_CAUSE:  assert property (@(posedge clk) disable iff (!rst_n) irq |-> (flags[6:4] != 3'b000)); // R6
  AST_SQW_OFF:    assert property (@(posedge clk) disable iff (!rst_n) (rate_sel == '0) |-> !sqw); // R2
endmodule

// File: tb/rtc_periodic_irq_bench.sv
module rtc_periodic_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic [6:3] ctrl_en = 4'b0000;
  logic       alarm_evt = 1'b0;
  logic       upd_evt = 1'b0;
  logic       flag_rd = 1'b0;
  logic [7:0] flags;
  logic       irq;
  logic       sqw;

  int errors = 0;
  int checks = 0;
  int n_ticks = 0;
  logic mp = 1'b0, ma = 1'b0, mu = 1'b0;

  always #2 clk = ~clk;

  rtc_periodic_irq u_rtc_periodic_irq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_sel(rate_sel), .ctrl_en(ctrl_en),
    .alarm_evt(alarm_evt), .upd_evt(upd_evt), .flag_rd(flag_rd),
    .flags(flags), .irq(irq), .sqw(sqw)
  );

  function automatic int period_of(input logic [3:0] r);
    int e;
    e = (r == 4'd1) ? 8 : (r == 4'd2) ? 9 : int'(r);
    return 1 << (e - 1);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic t, input logic a, input logic u, input logic rd);
    int p;
    logic pe, summ, sq;
    tick = t; alarm_evt = a; upd_evt = u; flag_rd = rd;
    @(posedge clk);
    p  = period_of(rate_sel);
    pe = 1'b0;
    if (t) begin
      n_ticks = (n_ticks + 1) % 16384;
      pe = (rate_sel != 4'd0) && (n_ticks % p == 0);
    end
    mp = pe | (mp & ~rd);
    ma = a  | (ma & ~rd);
    mu = u  | (mu & ~rd);
    #1;
    summ = (mp & ctrl_en[6]) | (ma & ctrl_en[5]) | (mu & ctrl_en[4]);
    sq   = ctrl_en[3] && (rate_sel != 4'd0) && ((n_ticks % p) >= p / 2);
    chk(rate_sel == 4'd0 ? "R2" : (rate_sel < 4'd3 ? "R4" : "R3"), 8'(flags[6]), 8'(mp));
    chk(rd ? "R7" : "R5", 8'(flags[5:4]), 8'({ma, mu}));
    chk("R6", 8'(flags[7]), 8'(summ));
    chk("R6", 8'(irq), 8'(summ));
    chk("R8", 8'(flags[3:0]), 8'h00);
    chk(rate_sel == 4'd0 ? "R2" : "R9", 8'(sqw), 8'(sq));
  endtask

  task automatic run_ticks(input int cnt);
    for (int i = 0; i < cnt; i++) step(1'b1, 1'b0, 1'b0, (i % 7) == 6);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    chk("R1", flags, 8'h00);
    chk("R1", 8'(irq), 8'h00);
    chk("R1", 8'(sqw), 8'h00);

    ctrl_en = 4'b1111;
    rate_sel = 4'd0;
    run_ticks(300);
    rate_sel = 4'd3;
    run_ticks(100);
    rate_sel = 4'd6;
    run_ticks(200);
    rate_sel = 4'd1;
    run_ticks(600);
    rate_sel = 4'd2;
    run_ticks(1100);

    ctrl_en = 4'b0000;
    step(1'b0, 1'b1, 1'b1, 1'b0);
    chk("R6", 8'(irq), 8'h00);
    ctrl_en = 4'b0100;
    #1 chk("R6", flags, 8'hB0);
    step(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R7", flags, 8'hA0);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    chk("R7", flags, 8'h00);

    ctrl_en = 4'b1001;
    rate_sel = 4'd15;
    run_ticks(17000);

    for (int i = 0; i < 40000; i++) begin
      if ($urandom_range(99) == 0) rate_sel = 4'($urandom_range(15));
      if ($urandom_range(99) == 0) ctrl_en = 4'($urandom_range(15));
      step($urandom_range(1) == 1, $urandom_range(31) == 0,
           $urandom_range(31) == 0, $urandom_range(9) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule